// File: doc/BRIEF.md
# Masked register command sequencer

This block walks a list of commands held in a word-addressed command memory and carries them out one at a time, with no processor involved. A start pulse gives the word offset of the first command. Each command begins with a header word whose low byte is the opcode. Operand words follow the header directly. When an end-of-list header is reached, the block raises a one-cycle done pulse and goes idle.

Commands reach 32-bit peripheral registers over a simple request/ready register bus. The write command stores a full value. The merge-write command reads a register and changes only the bits selected by a mask. The copy command moves one register's value to another, and the masked copy merges a source into a destination under a mask. The compare command reads a register, masks it and checks the result against an expected value, jumping to another command offset on a mismatch. The output command sets or flips one of a bank of direct-control lines. A timer command hands its 24-bit argument to a separate timer block and waits for that block's acknowledge. The null opcode does nothing, and any opcode that is not defined is treated as null.

A load strobe copies an initial level pattern onto the control lines, normally before the first handler is started. The command memory is a synchronous RAM with its own write port, so the list can be filled from outside.

Top module: `regseq_top`

## Requirements
- R1: After reset, done, bus_req and tmr_req are 0 and every control line in odc_o is 0.
- R2: Opcode 0x01 (operands: address, data) performs exactly one bus write of data to address. Execution begins at the word offset given by start_addr.
- R3: Opcode 0x02 (operands: address, mask, data) reads the register and then writes back (read & ~mask) | (data & mask) to the same address.
- R4: Opcode 0x03 (operands: source, destination) reads the source and writes that value unchanged to the destination, using two bus transfers.
- R5: Opcode 0x04 (operands: source, destination, mask) reads the source, then the destination, and writes (dest & ~mask) | (src & mask) to the destination.
- R6: Opcode 0x05 (operands: address, mask, expected; header bits [31:16] hold the jump offset) reads the register. If (value & mask) differs from expected, execution continues at the jump offset; otherwise it continues with the next command.
- R7: Opcode 0x06 has no operands. Header bits [15:8] give the line index, bit 16 is toggle and bit 17 is the value. With toggle at 1 the line flips and the value bit is ignored; with toggle at 0 the line takes the value bit.
- R8: An output command whose index is 127 or higher (for example 0x7F or 0xC3) changes no line.
- R9: Opcode 0x00 and undefined opcodes issue no bus transfer and pass to the next word.
- R10: Opcode 0xFF ends the list. done is high for exactly one cycle, and no bus or timer request is pending while it is high.
- R11: Only one bus transfer is outstanding at a time. Once raised, bus_req and its address, direction and write data hold steady until a cycle with bus_ready high.
- R12: Opcode 0x07 raises tmr_req with tmr_arg equal to header bits [31:8] and holds it until tmr_ack. No later command starts before that acknowledge.
- R13: While odc_load is high, the lines take odc_init on the next edge, and this wins over an output command in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted when idle |
| start_addr | input | AW | Word offset of the first command |
| done | output | 1 | One-cycle pulse at end of list |
| cmem_we | input | 1 | Command memory write enable |
| cmem_waddr | input | AW | Command memory write offset |
| cmem_wdata | input | 32 | Command memory write word |
| bus_req | output | 1 | Register bus request |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | BAW | Register address |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Transfer completes this cycle |
| bus_rdata | input | 32 | Read data, valid with bus_ready |
| tmr_req | output | 1 | Timer command request |
| tmr_arg | output | 24 | Timer command argument |
| tmr_ack | input | 1 | Timer block acknowledge |
| odc_load | input | 1 | Load initial line levels |
| odc_init | input | NOUT | Initial line levels |
| odc_o | output | NOUT | Direct-control output lines |

## Verification
Two things can update the control lines in the same cycle: the load strobe and an output command coming out of the command list. The bench holds odc_load high for the whole run of a list made of output commands, so every line update falls in a load cycle. It then judges the lines against odc_init alone. In a separate run without the load, the same list is checked for toggle, set and out-of-range indices at the ports.

// File: rtl/regseq_pkg.sv
package regseq_pkg;
  localparam int DW = 32;

  localparam logic [7:0] OP_NULL  = 8'h00;
  localparam logic [7:0] OP_WRITE = 8'h01;
  localparam logic [7:0] OP_RMW   = 8'h02;
  localparam logic [7:0] OP_COPY  = 8'h03;
  localparam logic [7:0] OP_MCOPY = 8'h04;
  localparam logic [7:0] OP_CMP   = 8'h05;
  localparam logic [7:0] OP_OUT   = 8'h06;
  localparam logic [7:0] OP_TMR   = 8'h07;
  localparam logic [7:0] OP_END   = 8'hFF;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_HDR, S_OPF, S_OPC, S_EXEC, S_BUS, S_TMR
  } seq_state_e;

  // number of operand words after the header
  function automatic logic [1:0] op_words(input logic [7:0] op);
    case (op)
      OP_WRITE, OP_COPY:        op_words = 2'd2;
      OP_RMW, OP_MCOPY, OP_CMP: op_words = 2'd3;
      default:                  op_words = 2'd0;
    endcase
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] base,
                                          input logic [DW-1:0] mask,
                                          input logic [DW-1:0] newv);
    merge = (base & ~mask) | (newv & mask);
  endfunction
endpackage

// File: rtl/regseq_cmem.sv
module regseq_cmem #(
  parameter int AW = 9,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/regseq_odc.sv
module regseq_odc #(
  parameter int NOUT = 127,
  parameter int IW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [NOUT-1:0] init,
  input  logic            we,
  input  logic [IW-1:0]   idx,
  input  logic            tog,
  input  logic            val,
  output logic [NOUT-1:0] lines
);
  for (genvar i = 0; i < NOUT; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst)                        lines[i] <= 1'b0;
      else if (load)                  lines[i] <= init[i];
      else if (we && idx == IW'(i))   lines[i] <= tog ? ~lines[i] : val;
    end
  end
endmodule

// File: rtl/regseq_ctrl.sv
module regseq_ctrl
  import regseq_pkg::*;
#(
  parameter int AW  = 9,
  parameter int BAW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  output logic          done,
  output logic [AW-1:0] mem_raddr,
  input  logic [DW-1:0] mem_rdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic [BAW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ready,
  input  logic [DW-1:0] bus_rdata,
  output logic          tmr_req,
  output logic [23:0]   tmr_arg,
  input  logic          tmr_ack,
  output logic          odc_we,
  output logic [7:0]    odc_idx,
  output logic          odc_tog,
  output logic          odc_val
);
  seq_state_e    state;
  logic [AW-1:0] pc;
  logic [DW-1:0] hdr, op0, op1, op2, rd_a, rd_b;
  logic [1:0]    k, step;
  logic [7:0]    opc;

  logic          x_bus, x_we, x_tmr, x_out, x_end, x_jump;
  logic [DW-1:0] x_addr, x_wdata;

  assign mem_raddr = pc;
  assign opc       = hdr[7:0];

  // action for the current command step
  always_comb begin
    x_bus = 1'b0; x_we = 1'b0; x_tmr = 1'b0; x_out = 1'b0;
    x_end = 1'b0; x_jump = 1'b0;
    x_addr = op0; x_wdata = op1;
    case (opc)
      OP_WRITE: begin x_bus = (step == 2'd0); x_we = 1'b1; end
      OP_RMW: begin
        x_bus = (step != 2'd2);
        x_we  = (step == 2'd1);
        x_wdata = merge(rd_a, op1, op2);
      end
      OP_COPY: begin
        x_bus = (step != 2'd2);
        x_we  = (step == 2'd1);
        if (step == 2'd1) x_addr = op1;
        x_wdata = rd_a;
      end
      OP_MCOPY: begin
        x_bus = (step != 2'd3);
        x_we  = (step == 2'd2);
        if (step != 2'd0) x_addr = op1;
        x_wdata = merge(rd_b, op2, rd_a);
      end
      OP_CMP: begin
        x_bus  = (step == 2'd0);
        x_jump = (step == 2'd1) && ((rd_a & op1) != op2);
      end
      OP_OUT: x_out = 1'b1;
      OP_TMR: x_tmr = (step == 2'd0);
      OP_END: x_end = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; pc <= '0; hdr <= '0; k <= '0; step <= '0;
      op0 <= '0; op1 <= '0; op2 <= '0; rd_a <= '0; rd_b <= '0;
      done <= 1'b0; bus_req <= 1'b0; bus_we <= 1'b0;
      bus_addr <= '0; bus_wdata <= '0; tmr_req <= 1'b0; tmr_arg <= '0;
      odc_we <= 1'b0; odc_idx <= '0; odc_tog <= 1'b0; odc_val <= 1'b0;
    end else begin
      done   <= 1'b0;
      odc_we <= 1'b0;
      case (state)
        S_IDLE: if (start) begin pc <= start_addr; state <= S_FETCH; end
        S_FETCH: state <= S_HDR;
        S_HDR: begin
          hdr  <= mem_rdata;
          pc   <= pc + 1'b1;
          k    <= '0;
          step <= '0;
          state <= (op_words(mem_rdata[7:0]) == 2'd0) ? S_EXEC : S_OPF;
        end
        S_OPF: state <= S_OPC;
        S_OPC: begin
          case (k)
            2'd0:    op0 <= mem_rdata;
            2'd1:    op1 <= mem_rdata;
            default: op2 <= mem_rdata;
          endcase
          pc <= pc + 1'b1;
          if (k == op_words(opc) - 2'd1) state <= S_EXEC;
          else begin k <= k + 2'd1; state <= S_OPF; end
        end
        S_EXEC: begin
          if (x_out) begin
            odc_we  <= 1'b1;
            odc_idx <= hdr[15:8];
            odc_tog <= hdr[16];
            odc_val <= hdr[17];
          end
          if (x_bus) begin
            bus_req   <= 1'b1;
            bus_we    <= x_we;
            bus_addr  <= x_addr[BAW-1:0];
            bus_wdata <= x_wdata;
            state     <= S_BUS;
          end else if (x_tmr) begin
            tmr_req <= 1'b1;
            tmr_arg <= hdr[31:8];
            state   <= S_TMR;
          end else if (x_end) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            if (x_jump) pc <= hdr[16 +: AW];
            state <= S_FETCH;
          end
        end
        S_BUS: if (bus_ready) begin
          bus_req <= 1'b0;
          if (step == 2'd0) rd_a <= bus_rdata;
          if (step == 2'd1) rd_b <= bus_rdata;
          step  <= step + 2'd1;
          state <= S_EXEC;
        end
        S_TMR: if (tmr_ack) begin
          tmr_req <= 1'b0;
          step    <= step + 2'd1;
          state   <= S_EXEC;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/regseq_top.sv
module regseq_top
  import regseq_pkg::*;
#(
  parameter int AW   = 9,
  parameter int BAW  = 32,
  parameter int NOUT = 127
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [AW-1:0]   start_addr,
  output logic            done,
  input  logic            cmem_we,
  input  logic [AW-1:0]   cmem_waddr,
  input  logic [31:0]     cmem_wdata,
  output logic            bus_req,
  output logic            bus_we,
  output logic [BAW-1:0]  bus_addr,
  output logic [31:0]     bus_wdata,
  input  logic            bus_ready,
  input  logic [31:0]     bus_rdata,
  output logic            tmr_req,
  output logic [23:0]     tmr_arg,
  input  logic            tmr_ack,
  input  logic            odc_load,
  input  logic [NOUT-1:0] odc_init,
  output logic [NOUT-1:0] odc_o
);
  logic [AW-1:0] mem_raddr;
  logic [DW-1:0] mem_rdata;
  logic          odc_we, odc_tog, odc_val;
  logic [7:0]    odc_idx;

  regseq_cmem #(.AW(AW), .DW(DW)) cmem_i (
    .clk(clk), .we(cmem_we), .waddr(cmem_waddr), .wdata(cmem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  regseq_ctrl #(.AW(AW), .BAW(BAW)) ctrl_i (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .done(done),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .tmr_req(tmr_req), .tmr_arg(tmr_arg), .tmr_ack(tmr_ack),
    .odc_we(odc_we), .odc_idx(odc_idx), .odc_tog(odc_tog), .odc_val(odc_val)
  );

  regseq_odc #(.NOUT(NOUT), .IW(8)) odc_i (
    .clk(clk), .rst(rst), .load(odc_load), .init(odc_init),
    .we(odc_we), .idx(odc_idx), .tog(odc_tog), .val(odc_val), .lines(odc_o)
  );
endmodule

// File: rtl/regseq_chk.sv
module regseq_chk #(
  parameter int BAW  = 32,
  parameter int NOUT = 127
) (
  input logic            clk,
  input logic            rst,
  input logic            done,
  input logic            bus_req,
  input logic            bus_we,
  input logic [BAW-1:0]  bus_addr,
  input logic [31:0]     bus_wdata,
  input logic            bus_ready,
  input logic            tmr_req,
  input logic [23:0]     tmr_arg,
  input logic            tmr_ack,
  input logic            odc_we,
  input logic [7:0]      odc_idx,
  input logic            odc_tog,
  input logic            odc_val,
  input logic            odc_load,
  input logic [NOUT-1:0] odc_init,
  input logic [NOUT-1:0] odc_o
);
  logic [NOUT-1:0] sel;
  logic            in_range;
  assign sel      = NOUT'(1) << odc_idx;
  assign in_range = (32'(odc_idx) < NOUT);

  a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ready |=> bus_req && $stable(bus_addr) && $stable(bus_we)
                              && $stable(bus_wdata));

  a_r12_tmr_hold: assert property (@(posedge clk) disable iff (rst)
    tmr_req && !tmr_ack |=> tmr_req && $stable(tmr_arg));

  a_r12_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(tmr_req && bus_req));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> !bus_req && !tmr_req);

  a_r7_toggle: assert property (@(posedge clk) disable iff (rst)
    odc_we && odc_tog && in_range && !odc_load |=>
      odc_o == ($past(odc_o) ^ $past(sel)));

  a_r7_set: assert property (@(posedge clk) disable iff (rst)
    odc_we && !odc_tog && in_range && !odc_load |=>
      odc_o == (($past(odc_o) & ~$past(sel)) | ($past(odc_val) ? $past(sel) : '0)));

  a_r8_ignore: assert property (@(posedge clk) disable iff (rst)
    odc_we && !in_range && !odc_load |=> $stable(odc_o));

  a_r13_load: assert property (@(posedge clk) disable iff (rst)
    odc_load |=> odc_o == $past(odc_init));
endmodule

bind regseq_top regseq_chk #(.BAW(BAW), .NOUT(NOUT)) chk_i (
  .clk(clk), .rst(rst), .done(done), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
  .tmr_req(tmr_req), .tmr_arg(tmr_arg), .tmr_ack(tmr_ack),
  .odc_we(odc_we), .odc_idx(odc_idx), .odc_tog(odc_tog), .odc_val(odc_val),
  .odc_load(odc_load), .odc_init(odc_init), .odc_o(odc_o)
);

// File: tb/regseq_top_tb_top.sv
`timescale 1ns/1ps
module regseq_top_tb_top;
  localparam int AW = 9, BAW = 32, NOUT = 127;

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic            start = 0, done;
  logic [AW-1:0]   start_addr = '0;
  logic            cmem_we = 0;
  logic [AW-1:0]   cmem_waddr = '0;
  logic [31:0]     cmem_wdata = '0;
  logic            bus_req, bus_we, bus_ready = 0;
  logic [BAW-1:0]  bus_addr;
  logic [31:0]     bus_wdata, bus_rdata = '0;
  logic            tmr_req, tmr_ack = 0;
  logic [23:0]     tmr_arg;
  logic            odc_load = 0;
  logic [NOUT-1:0] odc_init = '0;
  logic [NOUT-1:0] odc_o;

  regseq_top #(.AW(AW), .BAW(BAW), .NOUT(NOUT)) dut_i (.*);

  int checks = 0, errors = 0;
  logic [31:0] regs [16];
  int lat = 0, wcnt = 0, bus_ops = 0, tcnt = 0, ops_at_ack = -1;
  logic [23:0] seen_arg = '0;

  // kind, a, b, c, expected
  localparam logic [159:0] TBL [8] = '{
    {32'd0, 32'hFFFF0000, 32'h00FF00FF, 32'h12345678, 32'hFF340078},
    {32'd0, 32'h00000000, 32'hFFFFFFFF, 32'hA5A5A5A5, 32'hA5A5A5A5},
    {32'd0, 32'hDEADBEEF, 32'h00000000, 32'h00000000, 32'hDEADBEEF},
    {32'd1, 32'h12345678, 32'hFFFFFFFF, 32'h0000FFFF, 32'hFFFF5678},
    {32'd1, 32'h00000000, 32'hF0F0F0F0, 32'hFF000000, 32'h00F0F0F0},
    {32'd2, 32'h000000AB, 32'h000000FF, 32'h000000AB, 32'h00000001},
    {32'd2, 32'h000012AB, 32'h000000FF, 32'h000000AB, 32'h00000001},
    {32'd2, 32'h000000AC, 32'h000000FF, 32'h000000AB, 32'h00000002}
  };

  function automatic logic [31:0] h(input logic [7:0] op);
    h = {24'h0, op};
  endfunction
  function automatic logic [31:0] h_out(input logic [7:0] idx, input logic tog, input logic val);
    h_out = {14'h0, val, tog, idx, 8'h06};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mw(input int a, input logic [31:0] d);
    cmem_we = 1; cmem_waddr = AW'(a); cmem_wdata = d;
    @(negedge clk);
    cmem_we = 0;
  endtask

  task automatic run(input int a);
    start = 1; start_addr = AW'(a);
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
  endtask

  task automatic bus_model();
    forever begin
      @(negedge clk);
      if (bus_ready) bus_ready = 0;
      else if (bus_req) begin
        if (wcnt < lat) wcnt++;
        else begin
          wcnt = 0; bus_ops++;
          if (bus_we) regs[bus_addr[3:0]] = bus_wdata;
          else bus_rdata = regs[bus_addr[3:0]];
          bus_ready = 1;
        end
      end
    end
  endtask

  task automatic tmr_model();
    forever begin
      @(negedge clk);
      if (tmr_ack) tmr_ack = 0;
      else if (tmr_req) begin
        tcnt++;
        if (tcnt == 4) begin
          tcnt = 0; tmr_ack = 1; seen_arg = tmr_arg; ops_at_ack = bus_ops;
        end
      end
    end
  endtask

  initial begin
    logic [NOUT-1:0] init_pat, exp_pat, touched;
    for (int i = 0; i < 16; i++) regs[i] = '0;
    fork
      bus_model();
      tmr_model();
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 done", 128'(done), 128'(0));
    chk("R1 bus_req", 128'(bus_req), 128'(0));
    chk("R1 tmr_req", 128'(tmr_req), 128'(0));
    chk("R1 odc_o", 128'(odc_o), 128'(0));

    // table walk: merge-write, masked copy, compare/jump, with bus wait states
    for (int i = 0; i < 8; i++) begin
      logic [31:0] kd, a, b, c, e;
      {kd, a, b, c, e} = TBL[i];
      lat = i % 3;
      if (kd == 0) begin
        regs[2] = a;
        mw(0, h(8'h02)); mw(1, 2); mw(2, b); mw(3, c); mw(4, h(8'hFF));
        run(0);
        chk($sformatf("R3 R11 row%0d", i), 128'(regs[2]), 128'(e));
      end else if (kd == 1) begin
        regs[2] = a; regs[3] = b;
        mw(0, h(8'h04)); mw(1, 2); mw(2, 3); mw(3, c); mw(4, h(8'hFF));
        run(0);
        chk($sformatf("R5 R11 row%0d", i), 128'(regs[3]), 128'(e));
      end else begin
        regs[2] = a; regs[10] = 0;
        mw(0, {16'd8, 8'h0, 8'h05}); mw(1, 2); mw(2, b); mw(3, c);
        mw(4, h(8'h01)); mw(5, 10); mw(6, 1); mw(7, h(8'hFF));
        mw(8, h(8'h01)); mw(9, 10); mw(10, 2); mw(11, h(8'hFF));
        run(0);
        chk($sformatf("R6 row%0d", i), 128'(regs[10]), 128'(e));
      end
    end
    lat = 1;

    // R2 plain write from a nonzero start offset
    mw(40, h(8'h01)); mw(41, 3); mw(42, 32'hCAFEF00D); mw(43, h(8'hFF));
    bus_ops = 0;
    run(40);
    chk("R2 value", 128'(regs[3]), 128'(32'hCAFEF00D));
    chk("R2 one transfer", 128'(bus_ops), 128'(1));
    chk("R10 no request at done", 128'({bus_req, tmr_req}), 128'(0));
    @(negedge clk);
    chk("R10 done one cycle", 128'(done), 128'(0));

    // R4 plain copy
    regs[4] = 32'h11223344; regs[5] = 0;
    mw(50, h(8'h03)); mw(51, 4); mw(52, 5); mw(53, h(8'hFF));
    bus_ops = 0;
    run(50);
    chk("R4 value", 128'(regs[5]), 128'(32'h11223344));
    chk("R4 two transfers", 128'(bus_ops), 128'(2));

    // R9 null and undefined opcodes
    mw(30, h(8'h00)); mw(31, h(8'h3C)); mw(32, h(8'h01)); mw(33, 6); mw(34, 77);
    mw(35, h(8'hFF));
    bus_ops = 0;
    run(30);
    chk("R9 transfers", 128'(bus_ops), 128'(1));
    chk("R9 next command ran", 128'(regs[6]), 128'(77));

    // R13 initial levels
    init_pat = (NOUT'(1) << 5) | (NOUT'(1) << 100);
    odc_init = init_pat; odc_load = 1;
    @(negedge clk);
    odc_load = 0;
    chk("R13 load", 128'(odc_o), 128'(init_pat));

    // R7 / R8 output commands
    mw(60, h_out(8'd5, 1'b1, 1'b1));
    mw(61, h_out(8'd9, 1'b0, 1'b1));
    mw(62, h_out(8'h7F, 1'b0, 1'b1));
    mw(63, h_out(8'hC3, 1'b1, 1'b0));
    mw(64, h_out(8'd100, 1'b0, 1'b1));
    mw(65, h(8'hFF));
    run(60);
    exp_pat = (init_pat ^ (NOUT'(1) << 5)) | (NOUT'(1) << 9);
    chk("R7 toggle and set", 128'(odc_o), 128'(exp_pat));
    touched = (NOUT'(1) << 5) | (NOUT'(1) << 9);
    chk("R8 out-of-range idle", 128'(odc_o & ~touched), 128'(init_pat & ~touched));

    // R13 load held while output commands run: load wins
    odc_load = 1;
    run(60);
    @(negedge clk);
    odc_load = 0;
    chk("R13 load priority", 128'(odc_o), 128'(init_pat));

    // R12 timer handoff
    regs[7] = 0;
    mw(20, {24'h0ABCDE, 8'h07}); mw(21, h(8'h01)); mw(22, 7); mw(23, 5);
    mw(24, h(8'hFF));
    bus_ops = 0; ops_at_ack = -1;
    run(20);
    chk("R12 argument", 128'(seen_arg), 128'(24'h0ABCDE));
    chk("R12 no transfer before ack", 128'(ops_at_ack), 128'(0));
    chk("R12 next command after ack", 128'(regs[7]), 128'(5));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule